// File: doc/BRIEF.md
# Quadrature Encoder Position Decoder

This block turns the phase A, phase B and index signals of an incremental encoder into a position count and a revolution count. Each pin is first brought into the clock domain by a two-stage synchronizer. It then passes through a digital filter that holds back any change until the new level has stayed put for a programmed number of samples. A step decoder then produces count steps. It works either in quadrature mode, at 2X or 4X resolution, or in clock/direction mode.

The position counter runs between zero and a programmable maximum, wrapping in both directions. It can be cleared at once, or armed to clear on the next index pulse. Three position comparators and one revolution comparator raise sticky event flags. Three more flags mark a position match and a revolution match that are both present. Software reaches the block through a plain write port: one address and one data word per cycle. The same port carries configuration, one-shot commands, limits, compare values, the filter length and a write-one-to-clear flag register.

Top module: `qdec_position_unit`

## Requirements
- R1: In quadrature mode with 4X counting (config bit 2 = 1), every change of filtered phase A or phase B moves the position by one. The upward order of the (A,B) states is 00, 10, 11, 01; the reverse order counts down.
- R2: In quadrature mode with 2X counting (config bit 2 = 0), only phase A changes move the position; phase B changes only set the direction context.
- R3: With config bit 1 = 1 (clock/direction), phase A is the count clock and phase B the direction (0 = up, 1 = down). 2X counts rising A edges only, 4X counts both A edges, and a change of B alone never counts.
- R4: Config bit 0 reverses the counting direction. Output `dir_down` holds 1 when the last counted step went down and 0 when it went up.
- R5: Counting up from the maximum position (address 2) gives 0, and counting down from 0 loads the maximum. The maximum resets to all ones.
- R6: In quadrature mode, a change of A and B in the same filtered cycle sets flag bit 4 (phase error) and leaves the position unchanged.
- R7: A rising edge of (index XOR config bit 3) adds one to `rev_count` and sets flag bit 0. With bit 3 set, a raw rising index edge does not count and the following falling edge does.
- R8: A write to address 1 issues one-shot commands. Bit 0 clears the position, bit 3 clears the revolution count, and bit 1 arms a single clear of the position at the next index pulse. A step taken while armed still counts, and a later pulse no longer clears.
- R9: Flag bit 6+k sets when the position takes a new value equal to position compare k (addresses 3, 4, 5). Flag bit 9 sets when `rev_count` takes a new value equal to the index compare (address 6).
- R10: Flag bit 10+k is set only when flag bit 6+k and flag bit 9 are both set.
- R11: The filter length F (address 7, reset 0) makes each input change wait until the synchronized level has differed from the filtered level for F+1 consecutive cycles; shorter pulses are dropped.
- R12: Flag bit 5 sets on every counted step and flag bit 3 on a counted step whose direction differs from the last one. All flags are sticky and are cleared by writing ones to address 8; a new event wins over a clear in the same cycle.
- R13: After reset, position, `rev_count`, `dir_down` and all flags are 0 and the config word (address 0) is 0. Flag bits 1 and 2 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B (asynchronous) |
| enc_idx | input | 1 | Encoder index (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | CNT_W | Register write data |
| position | output | CNT_W | Position counter |
| rev_count | output | CNT_W | Revolution (index) counter |
| dir_down | output | 1 | Direction of the last counted step, 1 = down |
| flags | output | FLAG_W | Sticky event flags |

## Verification
The bench walks the quadrature state ring in both directions, once at 4X and once at 2X. At 4X every state counts; at 2X the A-only and B-only transitions give different results, which tells the two rates apart. Clock/direction stimulus toggles A with B held at each level and also toggles B alone. This separates rising-only from both-edge counting, and clock edges from direction changes. Further patterns check the boundaries and flags: wraps at a small maximum, a double-phase jump for the phase error, and index pulses with and without inversion. A glitch shorter than the filter window is compared against a held step. Compare hits are checked before and after the revolution match, so the combined flags show apart from their inputs.

// File: rtl/qd_pkg.sv
package qd_pkg;
  // Configuration word, bit 0 at the right.
  typedef struct packed {
    logic idx_inv;
    logic x4;
    logic clk_dir;
    logic dir_inv;
  } qd_cfg_t;

  localparam int ADR_CFG  = 0;
  localparam int ADR_CMD  = 1;
  localparam int ADR_MAX  = 2;
  localparam int ADR_CMP0 = 3;

  localparam int CMD_POS_CLR = 0;
  localparam int CMD_ARM     = 1;
  localparam int CMD_IDX_CLR = 3;

  localparam int FL_INDEX  = 0;
  localparam int FL_DIRCHG = 3;
  localparam int FL_PHERR  = 4;
  localparam int FL_COUNT  = 5;
  localparam int FL_POS0   = 6;
endpackage

// File: rtl/qd_input_filter.sv
module qd_input_filter #(
  parameter int FILT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic [FILT_W-1:0] flen,
  output logic              dout
);
  logic              s1, s2, q;
  logic [FILT_W-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1  <= 1'b0;
      s2  <= 1'b0;
      q   <= 1'b0;
      run <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
      if (s2 != q) begin
        if (run >= flen) begin
          q   <= s2;
          run <= '0;
        end else begin
          run <= run + FILT_W'(1);
        end
      end else begin
        run <= '0;
      end
    end
  end

  assign dout = q;

  // A filtered change must come from a level that waited out the window
  p_filter_window_r11: assert property (@(posedge clk) disable iff (rst)
    (q != $past(q)) |-> ($past(s2) == q && $past(run) >= $past(flen)));
endmodule

// File: rtl/qd_step_decode.sv
module qd_step_decode
  import qd_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  qd_cfg_t cfg,
  input  logic    a,
  input  logic    b,
  input  logic    idx,
  output logic    step,
  output logic    fwd,
  output logic    ph_err,
  output logic    idx_pulse
);
  logic pa, pb, pidx;
  logic ea, eb, raw_fwd;

  always_ff @(posedge clk) begin
    if (rst) begin
      pa   <= 1'b0;
      pb   <= 1'b0;
      pidx <= 1'b0;
    end else begin
      pa   <= a;
      pb   <= b;
      pidx <= idx;
    end
  end

  always_comb begin
    ea = a ^ pa;
    eb = b ^ pb;
    if (cfg.clk_dir) begin
      ph_err  = 1'b0;
      step    = cfg.x4 ? ea : (ea & a);
      raw_fwd = ~b;
    end else begin
      ph_err  = ea & eb;
      step    = ~(ea & eb) & (ea | (cfg.x4 & eb));
      raw_fwd = ea ? (a != b) : (a == b);
    end
    fwd       = raw_fwd ^ cfg.dir_inv;
    idx_pulse = (idx ^ cfg.idx_inv) & ~(pidx ^ cfg.idx_inv);
  end

  // R6: a double-phase change never counts
  p_err_blocks_step_r6: assert property (@(posedge clk) disable iff (rst)
    ph_err |-> !step);
endmodule

// File: rtl/qd_counters.sv
module qd_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             fwd,
  input  logic             idx_pulse,
  input  logic             cmd_pos_clr,
  input  logic             cmd_idx_clr,
  input  logic             cmd_arm,
  input  logic [CNT_W-1:0] max_pos,
  output logic [CNT_W-1:0] pos,
  output logic [CNT_W-1:0] icnt,
  output logic             pos_upd,
  output logic             idx_upd,
  output logic             dir_down,
  output logic             dir_chg
);
  logic armed;
  logic idx_load;

  assign idx_load = idx_pulse & armed;
  assign dir_chg  = step & ((~fwd) != dir_down);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos      <= '0;
      icnt     <= '0;
      armed    <= 1'b0;
      dir_down <= 1'b0;
      pos_upd  <= 1'b0;
      idx_upd  <= 1'b0;
    end else begin
      pos_upd <= 1'b0;
      idx_upd <= 1'b0;
      if (idx_load) armed <= 1'b0;
      if (cmd_arm)  armed <= 1'b1;
      if (cmd_pos_clr || idx_load) begin
        pos     <= '0;
        pos_upd <= 1'b1;
      end else if (step) begin
        if (fwd) pos <= (pos == max_pos) ? '0 : pos + CNT_W'(1);
        else     pos <= (pos == '0) ? max_pos : pos - CNT_W'(1);
        pos_upd <= 1'b1;
      end
      if (step) dir_down <= ~fwd;
      if (cmd_idx_clr) begin
        icnt    <= '0;
        idx_upd <= 1'b1;
      end else if (idx_pulse) begin
        icnt    <= icnt + CNT_W'(1);
        idx_upd <= 1'b1;
      end
    end
  end

  p_wrap_up_r5: assert property (@(posedge clk) disable iff (rst)
    (step && fwd && !cmd_pos_clr && !idx_load && pos == max_pos) |=> pos == '0);
  p_wrap_down_r5: assert property (@(posedge clk) disable iff (rst)
    (step && !fwd && !cmd_pos_clr && !idx_load && pos == '0) |=> pos == $past(max_pos));
  p_pos_clear_r8: assert property (@(posedge clk) disable iff (rst)
    cmd_pos_clr |=> pos == '0);
  p_rev_inc_r7: assert property (@(posedge clk) disable iff (rst)
    (idx_pulse && !cmd_idx_clr) |=> icnt == $past(icnt) + CNT_W'(1));
endmodule

// File: rtl/qd_event_flags.sv
module qd_event_flags
  import qd_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_CMP  = 3,
  localparam int FL_REV   = FL_POS0 + N_CMP,
  localparam int FL_BOTH0 = FL_REV + 1,
  localparam int FLAG_W   = FL_BOTH0 + N_CMP
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [CNT_W-1:0]            pos,
  input  logic [CNT_W-1:0]            icnt,
  input  logic                        pos_upd,
  input  logic                        idx_upd,
  input  logic [N_CMP-1:0][CNT_W-1:0] cmp_vals,
  input  logic [CNT_W-1:0]            icmp,
  input  logic                        ev_index,
  input  logic                        ev_dirchg,
  input  logic                        ev_pherr,
  input  logic                        ev_count,
  input  logic [FLAG_W-1:0]           clr_mask,
  output logic [FLAG_W-1:0]           flags
);
  logic [FLAG_W-1:0] nxt;

  always_comb begin
    nxt = flags & ~clr_mask;
    nxt[FL_INDEX]  = nxt[FL_INDEX]  | ev_index;
    nxt[FL_DIRCHG] = nxt[FL_DIRCHG] | ev_dirchg;
    nxt[FL_PHERR]  = nxt[FL_PHERR]  | ev_pherr;
    nxt[FL_COUNT]  = nxt[FL_COUNT]  | ev_count;
    for (int k = 0; k < N_CMP; k++)
      nxt[FL_POS0+k] = nxt[FL_POS0+k] | (pos_upd && pos == cmp_vals[k]);
    nxt[FL_REV] = nxt[FL_REV] | (idx_upd && icnt == icmp);
    for (int k = 0; k < N_CMP; k++)
      nxt[FL_BOTH0+k] = nxt[FL_BOTH0+k] | (nxt[FL_POS0+k] & nxt[FL_REV]);
    nxt[1] = 1'b0;
    nxt[2] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= nxt;
  end

  for (genvar k = 0; k < N_CMP; k++) begin : g_both_chk
    // R10: a combined flag rises only with both of its sources present
    p_both_needs_pair_r10: assert property (@(posedge clk) disable iff (rst)
      $rose(flags[FL_BOTH0+k]) |-> (flags[FL_POS0+k] && flags[FL_REV]));
  end

  // R13: reserved flag bits stay clear
  p_reserved_zero_r13: assert property (@(posedge clk) disable iff (rst)
    flags[2:1] == 2'b00);
endmodule

// File: rtl/qdec_position_unit.sv
module qdec_position_unit
  import qd_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FILT_W = 8,
  parameter int N_CMP  = 3,
  parameter int ADDR_W = 4,
  localparam int FLAG_W   = FL_POS0 + 2 * N_CMP + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              enc_idx,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  position,
  output logic [CNT_W-1:0]  rev_count,
  output logic              dir_down,
  output logic [FLAG_W-1:0] flags
);
  localparam int ADR_ICMP = ADR_CMP0 + N_CMP;
  localparam int ADR_FILT = ADR_ICMP + 1;
  localparam int ADR_FCLR = ADR_FILT + 1;

  qd_cfg_t                     cfg;
  logic [CNT_W-1:0]            max_pos, icmp;
  logic [N_CMP-1:0][CNT_W-1:0] cmp_vals;
  logic [FILT_W-1:0]           flen;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '0;
      max_pos  <= '1;
      icmp     <= '0;
      cmp_vals <= '0;
      flen     <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(ADR_CFG))  cfg     <= qd_cfg_t'(wr_data[3:0]);
      if (wr_addr == ADDR_W'(ADR_MAX))  max_pos <= wr_data;
      if (wr_addr == ADDR_W'(ADR_ICMP)) icmp    <= wr_data;
      if (wr_addr == ADDR_W'(ADR_FILT)) flen    <= wr_data[FILT_W-1:0];
      for (int k = 0; k < N_CMP; k++)
        if (wr_addr == ADDR_W'(ADR_CMP0 + k)) cmp_vals[k] <= wr_data;
    end
  end

  logic cmd_wr;
  assign cmd_wr = wr_en && (wr_addr == ADDR_W'(ADR_CMD));

  logic [FLAG_W-1:0] clr_mask;
  assign clr_mask = (wr_en && wr_addr == ADDR_W'(ADR_FCLR)) ? wr_data[FLAG_W-1:0] : '0;

  // Synchronize and filter the three encoder pins
  logic [2:0] raw_in, filt;
  assign raw_in = {enc_idx, enc_b, enc_a};

  for (genvar i = 0; i < 3; i++) begin : g_pin
    qd_input_filter #(.FILT_W(FILT_W)) u_filt (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_in[i]),
      .flen (flen),
      .dout (filt[i])
    );
  end

  logic step, fwd, ph_err, idx_pulse;

  qd_step_decode u_dec (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cfg),
    .a         (filt[0]),
    .b         (filt[1]),
    .idx       (filt[2]),
    .step      (step),
    .fwd       (fwd),
    .ph_err    (ph_err),
    .idx_pulse (idx_pulse)
  );

  logic pos_upd, idx_upd, dir_chg;

  qd_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .step        (step),
    .fwd         (fwd),
    .idx_pulse   (idx_pulse),
    .cmd_pos_clr (cmd_wr & wr_data[CMD_POS_CLR]),
    .cmd_idx_clr (cmd_wr & wr_data[CMD_IDX_CLR]),
    .cmd_arm     (cmd_wr & wr_data[CMD_ARM]),
    .max_pos     (max_pos),
    .pos         (position),
    .icnt        (rev_count),
    .pos_upd     (pos_upd),
    .idx_upd     (idx_upd),
    .dir_down    (dir_down),
    .dir_chg     (dir_chg)
  );

  qd_event_flags #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .pos       (position),
    .icnt      (rev_count),
    .pos_upd   (pos_upd),
    .idx_upd   (idx_upd),
    .cmp_vals  (cmp_vals),
    .icmp      (icmp),
    .ev_index  (idx_pulse),
    .ev_dirchg (dir_chg),
    .ev_pherr  (ph_err),
    .ev_count  (step),
    .clr_mask  (clr_mask),
    .flags     (flags)
  );

  // R6: a phase error leaves the position where it was
  p_err_holds_pos_r6: assert property (@(posedge clk) disable iff (rst)
    (ph_err && !cmd_wr && !idx_pulse) |=> $stable(position));
  // R4: the direction status only moves on a counted step
  p_dir_on_step_r4: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(dir_down));
endmodule

// File: tb/qdec_position_unit_test.sv
module qdec_position_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] position, rev_count;
  logic        dir_down;
  logic [12:0] flags;

  always #10 clk = ~clk;

  qdec_position_unit uut (
    .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .position(position), .rev_count(rev_count), .dir_down(dir_down), .flags(flags)
  );

  typedef struct {
    string       tag;
    int          kind;   // 0 position, 1 rev_count, 2 flags, 3 dir_down
    logic [15:0] mask;
    logic [15:0] exp;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  // Monitor: pops expected items and compares them with the outputs
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = position;
        1: act = rev_count;
        2: act = {3'b000, flags};
        default: act = {15'd0, dir_down};
      endcase
      checks++;
      if ((act & it.mask) !== (it.exp & it.mask)) begin
        fails++;
        $display("FAIL %s: got %h expected %h (mask %h)", it.tag, act & it.mask,
                 it.exp & it.mask, it.mask);
      end
    end
  end

  task automatic expect_val(int kind, logic [15:0] mask, logic [15:0] exp, string tag);
    item_t it;
    it.tag = tag; it.kind = kind; it.mask = mask; it.exp = exp;
    q.push_back(it);
  endtask

  // Bench-side state of the encoder and expected results
  int ph = 0;
  int settle = 8;
  logic [15:0] exp_pos = 0, maxp = 16'hFFFF;
  logic [15:0] exp_rev = 0;
  bit x4 = 0, dinv = 0;

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int addr, logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    wait_n(2);
  endtask

  task automatic clr_flags();
    wait_n(4);
    wr(8, 16'hFFFF);
  endtask

  task automatic drive_ph();
    enc_a = (ph == 1 || ph == 2);
    enc_b = (ph == 2 || ph == 3);
  endtask

  task automatic bump(bit up);
    if (up) exp_pos = (exp_pos == maxp) ? 16'd0 : exp_pos + 16'd1;
    else    exp_pos = (exp_pos == 16'd0) ? maxp : exp_pos - 16'd1;
  endtask

  // One quadrature state move: d = +1 up the ring, -1 down
  task automatic qmove(int d);
    bit a_edge;
    a_edge = (d > 0) ? (ph % 2 == 0) : (ph % 2 == 1);
    ph = (ph + d + 4) % 4;
    @(negedge clk);
    drive_ph();
    if (x4 || a_edge) bump((d > 0) ^ dinv);
    wait_n(settle);
  endtask

  task automatic pins(logic a, logic b);
    @(negedge clk);
    enc_a = a; enc_b = b;
    wait_n(settle);
  endtask

  task automatic idx_pulse_raw();
    @(negedge clk); enc_idx = 1'b1; wait_n(settle);
    @(negedge clk); enc_idx = 1'b0; wait_n(settle);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    wait_n(2);
    expect_val(0, 16'hFFFF, 16'h0000, "R13 reset position");
    expect_val(1, 16'hFFFF, 16'h0000, "R13 reset rev_count");
    expect_val(2, 16'hFFFF, 16'h0000, "R13 reset flags");
    expect_val(3, 16'h0001, 16'h0000, "R13 reset dir_down");

    // R1: 4X quadrature
    wr(0, 16'h0004); x4 = 1;
    for (int i = 0; i < 4; i++) qmove(1);
    expect_val(0, 16'hFFFF, exp_pos, "R1 four up states");
    expect_val(3, 16'h0001, 16'h0000, "R4 dir after up");
    qmove(-1);
    expect_val(0, 16'hFFFF, exp_pos, "R1 one down state");
    expect_val(3, 16'h0001, 16'h0001, "R4 dir after down");

    // R12: count and direction-change flags
    clr_flags();
    qmove(-1);
    expect_val(2, 16'h0028, 16'h0020, "R12 count without dir change");
    clr_flags();
    qmove(1);
    expect_val(2, 16'h0028, 16'h0028, "R12 count with dir change");
    expect_val(0, 16'hFFFF, exp_pos, "R1 position after reversal");

    // R2: 2X counts phase A changes only
    wr(0, 16'h0000); x4 = 0;
    for (int i = 0; i < 4; i++) qmove(1);
    expect_val(0, 16'hFFFF, exp_pos, "R2 full cycle at 2X");
    qmove(-1);
    expect_val(0, 16'hFFFF, exp_pos, "R2 single move at 2X");

    // R5: wrap at a small maximum
    wr(0, 16'h0004); x4 = 1;
    wr(2, 16'd7); maxp = 16'd7;
    while (exp_pos != 16'd7) qmove(1);
    qmove(1);
    expect_val(0, 16'hFFFF, 16'd0, "R5 wrap up to zero");
    qmove(-1);
    expect_val(0, 16'hFFFF, 16'd7, "R5 wrap down to max");
    qmove(1);
    expect_val(0, 16'hFFFF, 16'd0, "R5 back to zero");
    wr(2, 16'hFFFF); maxp = 16'hFFFF;

    // R6: both phases change together
    clr_flags();
    ph = (ph + 2) % 4;
    @(negedge clk); drive_ph(); wait_n(settle);
    expect_val(2, 16'h0030, 16'h0010, "R6 phase error flag");
    expect_val(0, 16'hFFFF, exp_pos, "R6 position held");

    // R4: direction inversion
    wr(0, 16'h0005); dinv = 1;
    qmove(1);
    expect_val(0, 16'hFFFF, exp_pos, "R4 inverted up move counts down");
    expect_val(3, 16'h0001, 16'h0001, "R4 inverted dir status");
    qmove(-1);
    wr(0, 16'h0004); dinv = 0;
    expect_val(0, 16'hFFFF, exp_pos, "R4 inverted return");

    // R9/R10: compares
    wr(3, 16'd2); wr(4, 16'd3); wr(5, 16'd5); wr(6, 16'd2);
    wr(1, 16'h0009); exp_pos = 0; exp_rev = 0;
    expect_val(0, 16'hFFFF, 16'd0, "R8 position clear command");
    expect_val(1, 16'hFFFF, 16'd0, "R8 rev clear command");
    clr_flags();
    for (int i = 0; i < 3; i++) qmove(1);
    expect_val(2, 16'h01C0, 16'h00C0, "R9 position compare hits");
    idx_pulse_raw(); exp_rev++;
    expect_val(1, 16'hFFFF, exp_rev, "R7 index counts");
    expect_val(2, 16'h1E01, 16'h0001, "R10 no combined before rev match");
    idx_pulse_raw(); exp_rev++;
    expect_val(2, 16'h1FC0, 16'h0EC0, "R10 combined with rev match R9");

    // R12: write-one-to-clear of a single bit
    wr(8, 16'h0040);
    expect_val(2, 16'h04C0, 16'h0480, "R12 selective clear");

    // R7: inverted index sense
    wr(0, 16'h000C);
    @(negedge clk); enc_idx = 1'b1; wait_n(settle);
    expect_val(1, 16'hFFFF, exp_rev, "R7 inverted rise ignored");
    @(negedge clk); enc_idx = 1'b0; wait_n(settle); exp_rev++;
    expect_val(1, 16'hFFFF, exp_rev, "R7 inverted fall counts");
    wr(0, 16'h0004);

    // R8: arm a clear on the next index
    wr(1, 16'h0002);
    qmove(1);
    expect_val(0, 16'hFFFF, exp_pos, "R8 step while armed");
    idx_pulse_raw(); exp_rev++; exp_pos = 0;
    expect_val(0, 16'hFFFF, 16'd0, "R8 cleared on index");
    qmove(1);
    idx_pulse_raw(); exp_rev++;
    expect_val(0, 16'hFFFF, exp_pos, "R8 second index no clear");
    expect_val(1, 16'hFFFF, exp_rev, "R7 rev count after pulses");
    wr(1, 16'h0008); exp_rev = 0;
    expect_val(1, 16'hFFFF, 16'd0, "R8 rev clear");
    wr(1, 16'h0001); exp_pos = 0;
    expect_val(0, 16'hFFFF, 16'd0, "R8 position clear");

    // R11: glitch filter
    wr(7, 16'd4); settle = 16;
    @(negedge clk); enc_a = ~enc_a; wait_n(3);
    enc_a = ~enc_a; wait_n(16);
    expect_val(0, 16'hFFFF, exp_pos, "R11 short glitch dropped");
    qmove(1);
    expect_val(0, 16'hFFFF, exp_pos, "R11 held change counts");
    wr(7, 16'd0); settle = 8;

    // R3: clock/direction
    while (ph != 0) qmove(1);
    wr(0, 16'h0002);
    pins(1, 0); bump(1);
    expect_val(0, 16'hFFFF, exp_pos, "R3 rising A counts up");
    pins(0, 0);
    expect_val(0, 16'hFFFF, exp_pos, "R3 falling A ignored at 2X");
    pins(0, 1);
    expect_val(0, 16'hFFFF, exp_pos, "R3 B alone ignored");
    pins(1, 1); bump(0);
    expect_val(0, 16'hFFFF, exp_pos, "R3 B high counts down");
    pins(0, 1);
    wr(0, 16'h0006);
    pins(1, 1); bump(0);
    pins(0, 1); bump(0);
    expect_val(0, 16'hFFFF, exp_pos, "R3 both A edges at 4X");
    pins(0, 0);
    pins(1, 0); bump(1);
    expect_val(0, 16'hFFFF, exp_pos, "R3 4X up");

    wait_n(4);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule